// File: doc/BRIEF.md
# Overlay Colour Priority Mixer

This block combines five overlay colour layers of a picture-in-picture display into a single overlay colour stream. The five layers are sub-select, sub-border, main-select, main-border and background. Each layer has a six-bit setting word that holds an enable, a brightness code and a colour type. Each layer also has a per-pixel coverage flag. On every clock the block finds the highest-priority layer that is both enabled and covering the pixel. It then turns that layer's colour type and brightness into 8-bit R, G and B intensity codes and two colour-difference codes, U and V, and it raises the fast-blank signal.

The clock runs at twice the pixel rate, so one clock is half a pixel. The colour outputs appear one clock after the inputs. The fast-blank output passes through a sixteen-stage shift line, and a signed setting selects the tap, which lets the overlay be keyed earlier or later in half-pixel steps. While no layer is shown, R, G and B are zero and U and V carry small signed pedestal offsets. These offsets can trim the white point of the downstream converters.

Top module: `overlay_mixer`

## Requirements
- R1: Layer k (0 = sub-select, 1 = sub-border, 2 = main-select, 3 = main-border, 4 = background) takes its setting from `layer_cfg_i[6k+5:6k]`. Within that word, bit 5 is the enable, bits 4:3 are the brightness code and bits 2:0 are the colour type.
- R2: A layer competes for a pixel only when its enable bit is 1 and its bit of `layer_act_i` is 1. A layer that is active but disabled, or enabled but inactive, has no effect on any output.
- R3: Among the competing layers, the one with the lowest index wins.
- R4: Colour type bit 0 drives blue, bit 1 drives red and bit 2 drives green. For types 1 to 6, each channel whose bit is set outputs round(p·255/100), where p is 30, 50, 70 or 100 % for brightness codes 0 to 3.
- R5: Type 0 (black) gives 0, 10, 30 or 50 % on all three channels, and type 7 (white) gives 60, 70, 80 or 100 % on all three, for brightness codes 0 to 3. These scale to 0, 26, 77, 128 and 153, 179, 204, 255.
- R6: For types 1 to 6, a channel whose colour bit is 0 outputs the black-column level for the selected brightness, not zero.
- R7: While a layer is shown, `u_o` equals floor((B−G)/2) and `v_o` equals floor((R−G)/2), both as two's-complement 8-bit values.
- R8: When `border_uv_inv_i` is 1 and the winning layer is a border layer (index 1 or 3), `u_o` becomes floor((G−B)/2) and `v_o` becomes floor((G−R)/2). Select layers and the background layer are unaffected.
- R9: When no layer competes, R, G and B are 0 and `u_o` and `v_o` are `ped_u_i` and `ped_v_i` sign-extended from 4 bits. When a layer is shown, no pedestal is added.
- R10: R, G, B, U and V reflect the inputs that were present at the previous rising clock edge.
- R11: Fast blank is high for a clock exactly when some layer competes. After each edge, `fb_o` shows the fast-blank value of the inputs sampled tap+1 edges earlier, where tap = `fb_delay_i` + 8 and `fb_delay_i` is signed 4-bit (−8..+7). A setting of −8 therefore aligns `fb_o` with the colour outputs.
- R12: While `rst_n` is low, every output is 0 and the fast-blank shift line holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| layer_cfg_i | input | 30 | Five 6-bit layer setting words, layer 0 in the low bits |
| layer_act_i | input | 5 | Per-pixel coverage flag of each layer |
| border_uv_inv_i | input | 1 | Negates U/V when a border layer wins |
| fb_delay_i | input | 4 | Signed fast-blank delay setting, −8..+7 |
| ped_u_i | input | 4 | Signed U pedestal used while fast blank is off |
| ped_v_i | input | 4 | Signed V pedestal used while fast blank is off |
| r_o | output | 8 | Red intensity code |
| g_o | output | 8 | Green intensity code |
| b_o | output | 8 | Blue intensity code |
| u_o | output | 8 | Signed U code |
| v_o | output | 8 | Signed V code |
| fb_o | output | 1 | Delayed fast-blank |

## Verification
The bench builds the block with its default parameters: five layers, 8-bit codes, a sixteen-stage delay line and 4-bit pedestals. With these values the full brightness law can be swept. Every colour type, brightness code, enable state and border inversion setting is applied to each of the five layers on its own, with the other layers carrying random but inactive settings. Random mixtures of layers then exercise the priority order, and the delay setting is varied over all sixteen taps against a history of expected fast-blank values. The most negative colour difference and every pedestal sign are reachable at these widths.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  localparam int CFG_W = 6;

  typedef struct packed {
    logic       en;
    logic [1:0] bright;
    logic [2:0] hue;
  } layer_cfg_t;

  // Brightness law, in percent of full scale
  function automatic int dark_pct(input logic [1:0] b);
    case (b)
      2'd0:    return 0;
      2'd1:    return 10;
      2'd2:    return 30;
      default: return 50;
    endcase
  endfunction

  function automatic int sat_pct(input logic [1:0] b);
    case (b)
      2'd0:    return 30;
      2'd1:    return 50;
      2'd2:    return 70;
      default: return 100;
    endcase
  endfunction

  function automatic int light_pct(input logic [1:0] b);
    case (b)
      2'd0:    return 60;
      2'd1:    return 70;
      2'd2:    return 80;
      default: return 100;
    endcase
  endfunction

  // Round a percentage onto a code of cw bits
  function automatic int pct_code(input int pct, input int cw);
    return (pct * ((1 << cw) - 1) + 50) / 100;
  endfunction

endpackage

// File: rtl/ovl_arbiter.sv
module ovl_arbiter #(
  parameter int LAYERS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAYERS-1:0] qual_i,
  output logic [LAYERS-1:0] grant_o,
  output logic              any_o
);

  // Lowest index has the highest priority: scan from the bottom up so
  // that the last hit is the winner.
  always_comb begin
    grant_o = '0;
    for (int i = LAYERS - 1; i >= 0; i--) begin
      if (qual_i[i]) grant_o = LAYERS'(1) << i;
    end
  end

  assign any_o = |qual_i;

  p_single_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_grant_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~qual_i) == '0);

  p_no_lower_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_i[0]) |-> grant_o[0]);

endmodule

// File: rtl/ovl_colour.sv
module ovl_colour
  import ovl_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    hue_i,
  input  logic [1:0]    bright_i,
  input  logic          uv_neg_i,
  output logic [CW-1:0] r_o,
  output logic [CW-1:0] g_o,
  output logic [CW-1:0] b_o,
  output logic [CW-1:0] u_o,
  output logic [CW-1:0] v_o
);

  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [CW-1:0]      lvl_off;
  logic [CW-1:0]      lvl_on;
  logic signed [CW:0] du;
  logic signed [CW:0] dv;

  always_comb begin
    lvl_off = CW'(pct_code(dark_pct(bright_i), CW));
    if (hue_i == 3'd7) lvl_on = CW'(pct_code(light_pct(bright_i), CW));
    else               lvl_on = CW'(pct_code(sat_pct(bright_i), CW));
  end

  assign b_o = hue_i[0] ? lvl_on : lvl_off;
  assign r_o = hue_i[1] ? lvl_on : lvl_off;
  assign g_o = hue_i[2] ? lvl_on : lvl_off;

  // Colour differences, negated before halving so the range stays symmetric
  always_comb begin
    du = $signed({1'b0, b_o}) - $signed({1'b0, g_o});
    dv = $signed({1'b0, r_o}) - $signed({1'b0, g_o});
    if (uv_neg_i) begin
      du = -du;
      dv = -dv;
    end
  end

  assign u_o = CW'(du >>> 1);
  assign v_o = CW'(dv >>> 1);

  p_white_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hue_i == 3'd7 && bright_i == 2'd3) |-> (r_o == FULL && g_o == FULL && b_o == FULL));

  p_black_dim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hue_i == 3'd0) |-> (r_o == g_o && g_o == b_o && u_o == '0 && v_o == '0));

endmodule

// File: rtl/ovl_fb_delay.sv
module ovl_fb_delay #(
  parameter int DEPTH = 16,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fb_i,
  input  logic [SW-1:0] setting_i,
  output logic          fb_o
);

  localparam logic [SW-1:0] MID = SW'(DEPTH / 2);

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_d;
  logic [SW-1:0]    tap;
  logic             seen_q;

  assign line_d = {line_q[DEPTH-2:0], fb_i};
  assign tap    = setting_i + MID;
  assign fb_o   = line_q[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      seen_q <= 1'b0;
    end else begin
      line_q <= line_d;
      seen_q <= 1'b1;
    end
  end

  p_shortest_tap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && setting_i == MID) |-> fb_o == $past(fb_i));

endmodule

// File: rtl/overlay_mixer.sv
module overlay_mixer
  import ovl_pkg::*;
#(
  parameter int LAYERS      = 5,
  parameter int CW          = 8,
  parameter int DLY_DEPTH   = 16,
  parameter int PW          = 4,
  parameter logic [LAYERS-1:0] BORDER_MASK = 5'b01010,
  localparam int DSW        = $clog2(DLY_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LAYERS*CFG_W-1:0] layer_cfg_i,
  input  logic [LAYERS-1:0]       layer_act_i,
  input  logic                    border_uv_inv_i,
  input  logic [DSW-1:0]          fb_delay_i,
  input  logic [PW-1:0]           ped_u_i,
  input  logic [PW-1:0]           ped_v_i,
  output logic [CW-1:0]           r_o,
  output logic [CW-1:0]           g_o,
  output logic [CW-1:0]           b_o,
  output logic [CW-1:0]           u_o,
  output logic [CW-1:0]           v_o,
  output logic                    fb_o
);

  layer_cfg_t        cfg_a [LAYERS];
  logic [LAYERS-1:0] qual;
  logic [LAYERS-1:0] grant;
  logic              any;
  layer_cfg_t        sel;
  logic              uv_neg;
  logic [CW-1:0]     c_r, c_g, c_b, c_u, c_v;
  logic [CW-1:0]     ped_u_x, ped_v_x;
  logic [CW-1:0]     r_d, g_d, b_d, u_d, v_d;
  logic              seen_q;

  for (genvar i = 0; i < LAYERS; i++) begin : g_layer
    assign cfg_a[i] = layer_cfg_i[i*CFG_W +: CFG_W];
    assign qual[i]  = cfg_a[i].en & layer_act_i[i];
  end

  ovl_arbiter #(.LAYERS(LAYERS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual_i  (qual),
    .grant_o (grant),
    .any_o   (any)
  );

  always_comb begin
    sel = '0;
    for (int i = 0; i < LAYERS; i++) begin
      if (grant[i]) sel = cfg_a[i];
    end
  end

  assign uv_neg = border_uv_inv_i & |(grant & BORDER_MASK);

  ovl_colour #(.CW(CW)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .hue_i    (sel.hue),
    .bright_i (sel.bright),
    .uv_neg_i (uv_neg),
    .r_o      (c_r),
    .g_o      (c_g),
    .b_o      (c_b),
    .u_o      (c_u),
    .v_o      (c_v)
  );

  assign ped_u_x = {{(CW-PW){ped_u_i[PW-1]}}, ped_u_i};
  assign ped_v_x = {{(CW-PW){ped_v_i[PW-1]}}, ped_v_i};

  // Next-state
  always_comb begin
    if (any) begin
      r_d = c_r;
      g_d = c_g;
      b_d = c_b;
      u_d = c_u;
      v_d = c_v;
    end else begin
      r_d = '0;
      g_d = '0;
      b_d = '0;
      u_d = ped_u_x;
      v_d = ped_v_x;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_o    <= '0;
      g_o    <= '0;
      b_o    <= '0;
      u_o    <= '0;
      v_o    <= '0;
      seen_q <= 1'b0;
    end else begin
      r_o    <= r_d;
      g_o    <= g_d;
      b_o    <= b_d;
      u_o    <= u_d;
      v_o    <= v_d;
      seen_q <= 1'b1;
    end
  end

  ovl_fb_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_i      (any),
    .setting_i (fb_delay_i),
    .fb_o      (fb_o)
  );

  p_pedestal_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(layer_act_i) == '0) |->
      (r_o == '0 && g_o == '0 && b_o == '0 && u_o == $past(ped_u_x) && v_o == $past(ped_v_x)));

  p_sub_select_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_act_i[0] && cfg_a[0].en) |-> sel == cfg_a[0]);

endmodule

// File: tb/test_overlay_mixer.sv
module test_overlay_mixer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [29:0] cfg;
  logic [4:0]  act;
  logic        inv;
  logic [3:0]  dly;
  logic [3:0]  pu, pv;
  logic [7:0]  r, g, b, u, v;
  logic        fb;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] hist;
  logic [7:0]  er, eg, eb, eu, ev;
  logic        efb;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  overlay_mixer i_overlay_mixer (
    .clk(clk), .rst_n(rst_n), .layer_cfg_i(cfg), .layer_act_i(act),
    .border_uv_inv_i(inv), .fb_delay_i(dly), .ped_u_i(pu), .ped_v_i(pv),
    .r_o(r), .g_o(g), .b_o(b), .u_o(u), .v_o(v), .fb_o(fb));

  function automatic int to_code(input int p);
    return (p * 255 + 50) / 100;
  endfunction

  function automatic int level(input logic [2:0] h, input logic [1:0] br, input logic bitset);
    int dk[4] = '{0, 10, 30, 50};
    int st[4] = '{30, 50, 70, 100};
    int wt[4] = '{60, 70, 80, 100};
    if (!bitset) return to_code(dk[br]);
    if (h == 3'd7) return to_code(wt[br]);
    return to_code(st[br]);
  endfunction

  task automatic model();
    int win = -1;
    for (int k = 4; k >= 0; k--)
      if (cfg[6*k+5] && act[k]) win = k;
    efb = (win >= 0);
    if (win < 0) begin
      er = 0; eg = 0; eb = 0;
      eu = {{4{pu[3]}}, pu};
      ev = {{4{pv[3]}}, pv};
    end else begin
      logic [2:0] h;
      logic [1:0] br;
      int du, dv;
      h  = cfg[6*win +: 3];
      br = cfg[6*win+3 +: 2];
      eb = 8'(level(h, br, h[0]));
      er = 8'(level(h, br, h[1]));
      eg = 8'(level(h, br, h[2]));
      du = int'(eb) - int'(eg);
      dv = int'(er) - int'(eg);
      if (inv && (win == 1 || win == 3)) begin
        du = -du;
        dv = -dv;
      end
      eu = 8'(du >>> 1);
      ev = 8'(dv >>> 1);
    end
  endtask

  task automatic check(input string tag, input logic [39:0] act_v, input logic [39:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  // Apply the current inputs at one edge and check all outputs after it
  task automatic step(input string rgb_tag, input string uv_tag);
    model();
    @(posedge clk);
    #1;
    hist = {hist[14:0], efb};
    check(rgb_tag, {16'd0, r, g, b}, {16'd0, er, eg, eb});
    check(uv_tag,  {24'd0, u, v},    {24'd0, eu, ev});
    check("R11 fast blank", {39'd0, fb}, {39'd0, hist[4'(dly + 4'd8)]});
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    cfg = '0; act = '0; inv = 1'b0; dly = 4'd8; pu = 4'hF; pv = 4'h3;
    hist = '0;
    act = 5'h1F; cfg = {5{6'b111111}};
    @(posedge clk); #1;
    // R12: reset holds everything at zero
    check("R12 reset rgb", {16'd0, r, g, b}, 40'd0);
    check("R12 reset uv/fb", {23'd0, u, v, fb}, 40'd0);
    @(negedge clk);
    act = '0; cfg = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive single-layer sweep, delay aligned (tap 0)
    dly = 4'd8;
    for (int l = 0; l < 5; l++) begin
      for (int c = 0; c < 64; c++) begin
        for (int iv = 0; iv < 2; iv++) begin
          string tr, tu;
          cfg = {$urandom, $urandom} & ~(30'h20 << (6*l));
          for (int k = 0; k < 5; k++) if (k != l) cfg[6*k+5] = $urandom_range(0, 1);
          cfg[6*l +: 6] = 6'(c);
          act = 5'(1 << l);
          inv = iv[0];
          pu = 4'($urandom); pv = 4'($urandom);
          if (c < 32)                            tr = "R2 disabled layer";
          else if (c[2:0] == 0 || c[2:0] == 7)   tr = "R5 black/white law";
          else                                   tr = "R4 R6 R10 saturated law";
          if (c < 32)                            tu = "R9 pedestal";
          else if (iv == 1 && (l == 1 || l == 3)) tu = "R8 border inversion";
          else                                   tu = "R7 colour difference";
          step(tr, tu);
        end
      end
    end

    // R1 R6: directed blue at brightness code 2 on the background layer
    cfg = '0; cfg[29:24] = 6'b1_10_001; act = 5'b10000; inv = 1'b1;
    model();
    @(posedge clk); #1;
    hist = {hist[14:0], 1'b1};
    check("R1 R6 blue br2", {16'd0, r, g, b}, {16'd0, 8'd77, 8'd77, 8'd179});
    check("R8 background not inverted", {24'd0, u, v}, {24'd0, 8'd51, 8'd0});
    @(negedge clk);

    // R3: all layers compete, sub-select red must win
    cfg = {6'b1_11_111, 6'b1_11_100, 6'b1_11_001, 6'b1_11_111, 6'b1_11_010};
    act = 5'h1F; inv = 1'b0;
    model();
    @(posedge clk); #1;
    hist = {hist[14:0], 1'b1};
    check("R3 top priority", {16'd0, r, g, b}, {16'd0, 8'd255, 8'd128, 8'd128});
    @(negedge clk);

    // R9: pedestal is not added while a layer is shown
    pu = 4'h7; pv = 4'h8;
    cfg = {24'd0, 6'b1_00_000}; act = 5'b00001;
    model();
    @(posedge clk); #1;
    hist = {hist[14:0], 1'b1};
    check("R9 no pedestal when shown", {24'd0, u, v}, 40'd0);
    @(negedge clk);
    act = 5'b0;
    model();
    @(posedge clk); #1;
    hist = {hist[14:0], 1'b0};
    check("R9 pedestal sign extend", {24'd0, u, v}, {24'd0, 8'h07, 8'hF8});
    @(negedge clk);

    // Random layer mixtures with every delay tap
    for (int n = 0; n < 6000; n++) begin
      cfg = {$urandom, $urandom};
      act = 5'($urandom);
      inv = $urandom_range(0, 1);
      if (n % 40 == 0) dly = 4'($urandom);
      pu = 4'($urandom); pv = 4'($urandom);
      step("R3 random priority", "R7 R8 R9 random uv");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule